// File: doc/BRIEF.md
# OSD Pixel Unpack and Blend

This block is the pixel datapath of an on-screen-display overlay. It accepts 32-bit words of stored overlay data on a valid/ready stream. It splits each word into one, two or four pixels, following a storage width setting. Each pixel is decoded into 8-bit alpha, red, green and blue by a colour format setting. Indexed pixels are looked up in a 256-entry colour table. The block applies colour keying, per-pixel alpha and a global alpha. The result leaves on a second valid/ready stream, ready for a downstream mixer to place over video.

The colour table is loaded through a small register write port. One write selects the entry and a second write supplies the 32-bit colour, which commits the entry. Everything else is a quasi-static configuration input. It may be changed only while the pipeline is empty.

Top module: `osd_pix_blend`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `cfg_bpp` sets the pixel slot size: 2'b10 gives 16-bit slots (two per word), 2'b11 gives 32-bit slots (one per word), and 2'b01 or 2'b00 gives 8-bit slots (four per word). Slots leave least-significant first, and a word is never accepted again until its last slot has been taken.
- R3: With 8-bit slots, `cfg_mode` has no effect and every pixel is an index. With wider slots, mode 3'b101 and any code outside 3'b001..3'b101 also mean index.
- R4: Direct modes use these layouts. 3'b001: R[15:11] G[10:5] B[4:0]. 3'b010: R[14:10] G[9:5] B[4:0], with bit 15 unused. 3'b011: R[11:8] G[7:4] B[3:0]. 3'b100: A[31:24] R[23:16] G[15:8] B[7:0]. A 5-bit channel v becomes {v, v[4:2]}, a 6-bit channel becomes {v, v[5:4]}, and a 4-bit channel becomes {v, v}.
- R5: Bits of a slot above those the mode uses are padding and never change the output. For example, an index uses slot bits [7:0] only. Mode 3'b100 in a 16-bit slot reads the slot zero-extended to 32 bits.
- R6: A register write with `reg_wr_addr`=0 loads the entry number from `reg_wr_data[7:0]`. A write with `reg_wr_addr`=1 stores `reg_wr_data` into that entry. Entries hold A[31:24] R[23:16] G[15:8] B[7:0], and an indexed pixel outputs its entry's colour.
- R7: When an entry is written in the same cycle that a pixel reads it, that pixel receives the previous contents.
- R8: With `cfg_key_en`=1, a pixel whose key field equals `cfg_key` gets alpha 0. The key field is slot bits [15:0] against `cfg_key[15:0]` in modes 3'b001/3'b010/3'b011, all 32 bits in mode 3'b100, and the index against `cfg_key[7:0]` in indexed mode.
- R9: Local alpha is the A byte in mode 3'b100 and indexed mode when `cfg_local_alpha_en`=1. Otherwise it is 255.
- R10: Output alpha is (L*G+127)/255 in integer arithmetic. L is the local alpha. G is `cfg_global_alpha` when `cfg_global_alpha_en`=1, else 255. R8 overrides this result.
- R11: Pixels leave in input order, none lost or repeated. While `out_valid`=1 and `out_ready`=0, the output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Colour format code |
| cfg_bpp | input | 2 | Storage slot size code |
| cfg_key_en | input | 1 | Enable colour keying |
| cfg_local_alpha_en | input | 1 | Enable per-pixel alpha |
| cfg_global_alpha_en | input | 1 | Enable global alpha |
| cfg_global_alpha | input | 8 | Global alpha value |
| cfg_key | input | 32 | Transparent key colour |
| reg_wr_en | input | 1 | Colour table register write strobe |
| reg_wr_addr | input | 1 | 0 = entry select, 1 = entry data |
| reg_wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_word | input | 32 | Stored pixel word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted |
| out_a | output | 8 | Effective alpha |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
A wrong slot counter shows at the ports within one word. The following pixel arrives from the wrong byte lane, or an extra or missing pixel shifts every later comparison in the stream. A table entry stored at the wrong address, or a read of the wrong port order, shows as a wrong colour on the first indexed pixel that reads that entry; the collision case shows on the pixel that crosses the write. An error in alpha or key handling appears two cycles after the word is accepted, on that pixel's alpha.

// File: rtl/osd_blend_pkg.sv
package osd_blend_pkg;

  // Storage slot size codes
  localparam logic [1:0] BPP_16 = 2'b10;
  localparam logic [1:0] BPP_32 = 2'b11;

  // Colour format codes at the configuration port
  localparam logic [2:0] MODE_565  = 3'b001;
  localparam logic [2:0] MODE_555  = 3'b010;
  localparam logic [2:0] MODE_444  = 3'b011;
  localparam logic [2:0] MODE_8888 = 3'b100;

  // Resolved internal format carried down the pipe
  typedef enum logic [2:0] {
    FMT_INDEX  = 3'd0,
    FMT_RGB565 = 3'd1,
    FMT_RGB555 = 3'd2,
    FMT_RGB444 = 3'd3,
    FMT_ARGB32 = 3'd4
  } pix_fmt_e;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

  // Narrow slots force indexing; unknown codes fall back to indexing
  function automatic pix_fmt_e resolve_fmt(input logic [2:0] mode, input logic [1:0] bpp);
    if (bpp != BPP_16 && bpp != BPP_32) return FMT_INDEX;
    case (mode)
      MODE_565:  return FMT_RGB565;
      MODE_555:  return FMT_RGB555;
      MODE_444:  return FMT_RGB444;
      MODE_8888: return FMT_ARGB32;
      default:   return FMT_INDEX;
    endcase
  endfunction

endpackage

// File: rtl/osd_unpack.sv
module osd_unpack
  import osd_blend_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bpp,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              take,
  output logic              pix_valid,
  output logic [WORD_W-1:0] pix_data
);
  localparam int LANES8  = WORD_W / 8;
  localparam int LANES16 = WORD_W / 16;
  localparam int SLOT_W  = (LANES8 > 1) ? $clog2(LANES8) : 1;

  logic [WORD_W-1:0] word_q;
  logic              hold_q;
  logic [SLOT_W-1:0] slot_q;
  logic              last_slot;

  logic [7:0]  lane8  [LANES8];
  logic [15:0] lane16 [LANES16];

  genvar gi;
  generate
    for (gi = 0; gi < LANES8; gi++) begin : g_lane8
      assign lane8[gi] = word_q[8*gi +: 8];
    end
    for (gi = 0; gi < LANES16; gi++) begin : g_lane16
      assign lane16[gi] = word_q[16*gi +: 16];
    end
  endgenerate

  always_comb begin
    case (bpp)
      BPP_32:  last_slot = 1'b1;
      BPP_16:  last_slot = (slot_q == SLOT_W'(LANES16 - 1));
      default: last_slot = (slot_q == SLOT_W'(LANES8 - 1));
    endcase
  end

  always_comb begin
    case (bpp)
      BPP_32:  pix_data = word_q;
      BPP_16:  pix_data = WORD_W'(lane16[slot_q[SLOT_W-2:0]]);
      default: pix_data = WORD_W'(lane8[slot_q]);
    endcase
  end

  assign pix_valid = hold_q;
  assign in_ready  = !hold_q || (take && last_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      slot_q <= '0;
      word_q <= '0;
    end else if (in_valid && in_ready) begin
      hold_q <= 1'b1;
      slot_q <= '0;
      word_q <= in_word;
    end else if (take && hold_q) begin
      if (last_slot) hold_q <= 1'b0;
      else           slot_q <= slot_q + 1'b1;
    end
  end

endmodule

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (wr_en && !wr_addr) sel_q <= wr_data[IDX_W-1:0];
  end

  // Read-before-write single clock array, maps to block RAM
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
    if (wr_en && wr_addr) mem[sel_q] <= wr_data;
  end

endmodule

// File: rtl/osd_convert.sv
module osd_convert
  import osd_blend_pkg::*;
(
  input  pix_fmt_e    fmt,
  input  logic [31:0] pix,
  input  logic [31:0] pal,
  input  logic [31:0] key,
  input  logic        key_en,
  input  logic        la_en,
  input  logic        ga_en,
  input  logic [7:0]  ga,
  output argb_t       px,
  output logic        key_hit
);
  logic [7:0]  la;
  logic [7:0]  gmul;
  logic [15:0] prod;
  logic [16:0] rnd;
  logic [16:0] scaled;

  always_comb begin
    la      = 8'hFF;
    key_hit = 1'b0;
    px      = '0;
    case (fmt)
      FMT_RGB565: begin
        px.r    = widen5(pix[15:11]);
        px.g    = widen6(pix[10:5]);
        px.b    = widen5(pix[4:0]);
        key_hit = (pix[15:0] == key[15:0]);
      end
      FMT_RGB555: begin
        px.r    = widen5(pix[14:10]);
        px.g    = widen5(pix[9:5]);
        px.b    = widen5(pix[4:0]);
        key_hit = (pix[15:0] == key[15:0]);
      end
      FMT_RGB444: begin
        px.r    = widen4(pix[11:8]);
        px.g    = widen4(pix[7:4]);
        px.b    = widen4(pix[3:0]);
        key_hit = (pix[15:0] == key[15:0]);
      end
      FMT_ARGB32: begin
        la      = pix[31:24];
        px.r    = pix[23:16];
        px.g    = pix[15:8];
        px.b    = pix[7:0];
        key_hit = (pix == key);
      end
      default: begin
        la      = pal[31:24];
        px.r    = pal[23:16];
        px.g    = pal[15:8];
        px.b    = pal[7:0];
        key_hit = (pix[7:0] == key[7:0]);
      end
    endcase
    if (!la_en) la = 8'hFF;
    gmul   = ga_en ? ga : 8'hFF;
    prod   = la * gmul;
    // Exact rounded divide by 255 for products up to 255*255
    rnd    = {1'b0, prod} + 17'd128;
    scaled = (rnd + (rnd >> 8)) >> 8;
    px.a   = (key_en && key_hit) ? 8'h00 : scaled[7:0];
  end

endmodule

// File: rtl/osd_pix_blend.sv
module osd_pix_blend
  import osd_blend_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_bpp,
  input  logic              cfg_key_en,
  input  logic              cfg_local_alpha_en,
  input  logic              cfg_global_alpha_en,
  input  logic [7:0]        cfg_global_alpha,
  input  logic [31:0]       cfg_key,
  input  logic              reg_wr_en,
  input  logic              reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_a,
  output logic [7:0]        out_r,
  output logic [7:0]        out_g,
  output logic [7:0]        out_b
);
  logic              advance;
  logic              u_valid;
  logic [WORD_W-1:0] u_pix;
  logic              u_take;

  logic              s1_valid;
  logic [31:0]       s1_pix;
  pix_fmt_e          s1_fmt;
  logic [31:0]       pal_rd;

  argb_t             conv_px;
  logic              conv_key_hit;

  assign advance = !out_valid || out_ready;
  assign u_take  = advance && u_valid;

  osd_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk       (clk),
    .rst       (rst),
    .bpp       (cfg_bpp),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .take      (u_take),
    .pix_valid (u_valid),
    .pix_data  (u_pix)
  );

  osd_palette #(.IDX_W(IDX_W), .DATA_W(32)) u_palette (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .rd_en   (advance),
    .rd_idx  (u_pix[IDX_W-1:0]),
    .rd_data (pal_rd)
  );

  // Stage 1: slot captured alongside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_fmt   <= FMT_INDEX;
    end else if (advance) begin
      s1_valid <= u_valid;
      s1_pix   <= 32'(u_pix);
      s1_fmt   <= resolve_fmt(cfg_mode, cfg_bpp);
    end
  end

  osd_convert u_convert (
    .fmt     (s1_fmt),
    .pix     (s1_pix),
    .pal     (pal_rd),
    .key     (cfg_key),
    .key_en  (cfg_key_en),
    .la_en   (cfg_local_alpha_en),
    .ga_en   (cfg_global_alpha_en),
    .ga      (cfg_global_alpha),
    .px      (conv_px),
    .key_hit (conv_key_hit)
  );

  // Stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_a     <= '0;
      out_r     <= '0;
      out_g     <= '0;
      out_b     <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      out_a     <= conv_px.a;
      out_r     <= conv_px.r;
      out_g     <= conv_px.g;
      out_b     <= conv_px.b;
    end
  end

endmodule

// File: rtl/osd_pix_blend_chk.sv
module osd_pix_blend_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg_mode,
  input logic [1:0] cfg_bpp,
  input logic       cfg_key_en,
  input logic       cfg_global_alpha_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_a,
  input logic [7:0] out_r,
  input logic [7:0] out_g,
  input logic [7:0] out_b,
  input logic       advance,
  input logic       s1_valid,
  input logic       conv_key_hit
);
  logic direct16;
  assign direct16 = (cfg_mode == 3'b001 || cfg_mode == 3'b010 || cfg_mode == 3'b011) &&
                    (cfg_bpp == 2'b10 || cfg_bpp == 2'b11);

  assert_reset_empty_R1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  assert_hold_stalled_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable({out_a, out_r, out_g, out_b}));

  assert_multi_slot_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && cfg_bpp != 2'b11 |=> !in_ready);

  assert_key_clear_R8: assert property (@(posedge clk) disable iff (rst)
    advance && s1_valid && cfg_key_en && conv_key_hit |=> out_a == 8'h00);

  assert_direct_opaque_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && direct16 && !cfg_key_en && !cfg_global_alpha_en |-> out_a == 8'hFF);

endmodule

bind osd_pix_blend osd_pix_blend_chk u_chk (
  .clk                 (clk),
  .rst                 (rst),
  .cfg_mode            (cfg_mode),
  .cfg_bpp             (cfg_bpp),
  .cfg_key_en          (cfg_key_en),
  .cfg_global_alpha_en (cfg_global_alpha_en),
  .in_valid            (in_valid),
  .in_ready            (in_ready),
  .out_valid           (out_valid),
  .out_ready           (out_ready),
  .out_a               (out_a),
  .out_r               (out_r),
  .out_g               (out_g),
  .out_b               (out_b),
  .advance             (advance),
  .s1_valid            (s1_valid),
  .conv_key_hit        (conv_key_hit)
);

// File: tb/osd_pix_blend_bench.sv
module osd_pix_blend_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_mode = 3'b101;
  logic [1:0]  cfg_bpp = 2'b01;
  logic        cfg_key_en = 1'b0;
  logic        cfg_local_alpha_en = 1'b0;
  logic        cfg_global_alpha_en = 1'b0;
  logic [7:0]  cfg_global_alpha = 8'hFF;
  logic [31:0] cfg_key = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_wr_addr = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_a, out_r, out_g, out_b;

  always #2.5 clk = ~clk;

  osd_pix_blend u_osd_pix_blend (.*);

  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  bit          ready_mode = 1'b0;
  bit          done = 1'b0;
  string       tag = "R11";
  logic [31:0] pal_m [256];
  logic [31:0] exp_q [$];

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] v = s;
    v = v ^ (v << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  function automatic int nslots();
    if (cfg_bpp == 2'b11) return 1;
    if (cfg_bpp == 2'b10) return 2;
    return 4;
  endfunction

  // Reference pixel from the requirements
  function automatic logic [31:0] ref_px(input logic [31:0] w, input int slot);
    logic [31:0] f;
    int nb, m, la, gv, a;
    logic [7:0] r, g, b;
    logic hit;
    nb = 32 / nslots();
    f = (nb == 32) ? w : ((w >> (slot * nb)) & ((32'd1 << nb) - 1));
    m = int'(cfg_mode);
    if (nb == 8 || m < 1 || m > 4) m = 5;
    la = 255;
    case (m)
      1: begin r = {f[15:11], f[15:13]}; g = {f[10:5], f[10:9]}; b = {f[4:0], f[4:2]};
               hit = (f[15:0] == cfg_key[15:0]); end
      2: begin r = {f[14:10], f[14:12]}; g = {f[9:5], f[9:7]}; b = {f[4:0], f[4:2]};
               hit = (f[15:0] == cfg_key[15:0]); end
      3: begin r = {2{f[11:8]}}; g = {2{f[7:4]}}; b = {2{f[3:0]}};
               hit = (f[15:0] == cfg_key[15:0]); end
      4: begin la = int'(f[31:24]); r = f[23:16]; g = f[15:8]; b = f[7:0];
               hit = (f == cfg_key); end
      default: begin la = int'(pal_m[f[7:0]][31:24]); r = pal_m[f[7:0]][23:16];
               g = pal_m[f[7:0]][15:8]; b = pal_m[f[7:0]][7:0];
               hit = (f[7:0] == cfg_key[7:0]); end
    endcase
    if (!cfg_local_alpha_en) la = 255;
    gv = cfg_global_alpha_en ? int'(cfg_global_alpha) : 255;
    a = (la * gv + 127) / 255;
    if (cfg_key_en && hit) a = 0;
    return {a[7:0], r, g, b};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Output side: drive ready and compare each accepted pixel
  always @(negedge clk) begin
    cyc++;
    out_ready = ready_mode ? ((cyc % 7) < 5) : 1'b1;
    #1;
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R11 extra pixel", {out_a, out_r, out_g, out_b}, 32'hDEAD_BEEF);
      else check(tag, {out_a, out_r, out_g, out_b}, exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R11 watchdog: got %0d cycles expected under 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic pal_write(input logic [7:0] idx, input logic [31:0] val);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_addr = 1'b0; reg_wr_data = {24'h0, idx};
    @(negedge clk); reg_wr_addr = 1'b1; reg_wr_data = val;
    @(negedge clk); reg_wr_en = 1'b0;
    pal_m[idx] = val;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int s = 0; s < nslots(); s++) exp_q.push_back(ref_px(w, s));
    @(negedge clk); in_valid = 1'b1; in_word = w; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk); in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic [1:0] bp, input bit ke,
                         input logic [31:0] k, input bit le, input bit ge, input logic [7:0] gav);
    cfg_mode = m; cfg_bpp = bp; cfg_key_en = ke; cfg_key = k;
    cfg_local_alpha_en = le; cfg_global_alpha_en = ge; cfg_global_alpha = gav;
  endtask

  task automatic rand_run(input int n, input logic [31:0] seed);
    logic [31:0] s = seed;
    for (int i = 0; i < n; i++) begin s = xs(s); send_word(s); end
  endtask

  initial begin
    logic [31:0] seed;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R1 out_valid", {31'h0, out_valid}, 32'h0);
    check("R1 in_ready", {31'h0, in_ready}, 32'h1);

    // R6: fill the whole colour table
    for (int i = 0; i < 256; i++) begin
      seed = xs(32'(i) * 32'h9E37 + 32'h1234);
      pal_write(8'(i), {8'(i) ^ 8'h3C, seed[23:0]});
    end
    ready_mode = 1'b1;

    // R2/R3/R6: 8-bit slots, all 256 indices, mode field ignored, index key
    tag = "R2 R3 R6 R8 R9";
    set_cfg(3'b001, 2'b01, 1'b1, 32'hFFFF_FFA7, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 64; k++) send_word({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    drain();
    tag = "R2 code 00";
    set_cfg(3'b100, 2'b00, 1'b0, 32'h0, 1'b0, 1'b0, 8'h00);
    rand_run(40, 32'h55AA_0001);
    drain();

    // R4/R5/R8: 565 in 16-bit slots, key on low half
    tag = "R4 R5 R8 565";
    set_cfg(3'b001, 2'b10, 1'b1, 32'h1234_ABCD, 1'b1, 1'b0, 8'h00);
    rand_run(200, 32'h0BAD_F00D);
    send_word(32'h5555_ABCD);
    drain();
    tag = "R4 R5 R8 R10 555";
    set_cfg(3'b010, 2'b11, 1'b1, 32'h0000_8421, 1'b1, 1'b1, 8'd128);
    rand_run(200, 32'hCAFE_0003);
    send_word(32'hFFFF_8421);
    drain();
    tag = "R4 R5 R9 444";
    set_cfg(3'b011, 2'b10, 1'b0, 32'h0, 1'b1, 1'b0, 8'h00);
    rand_run(200, 32'h0000_7777);
    drain();
    tag = "R4 R5 8888 in 16";
    set_cfg(3'b100, 2'b10, 1'b1, 32'h0000_1357, 1'b1, 1'b0, 8'h00);
    rand_run(100, 32'h2468_1357);
    send_word(32'h9999_1357);
    drain();
    tag = "R3 R5 index in 32";
    set_cfg(3'b101, 2'b11, 1'b0, 32'h0, 1'b1, 1'b1, 8'd200);
    rand_run(100, 32'h1111_2222);
    drain();
    tag = "R3 code 111";
    set_cfg(3'b111, 2'b11, 1'b0, 32'h0, 1'b1, 1'b0, 8'h00);
    rand_run(60, 32'h3333_4444);
    drain();

    // R10: local alpha swept against several global values
    for (int gi = 0; gi < 5; gi++) begin
      logic [7:0] gv;
      gv = (gi == 0) ? 8'd0 : (gi == 1) ? 8'd1 : (gi == 2) ? 8'd128 : (gi == 3) ? 8'd254 : 8'd255;
      tag = "R8 R9 R10 alpha sweep";
      set_cfg(3'b100, 2'b11, 1'b1, 32'h7F00_0000, 1'b1, 1'b1, gv);
      seed = 32'h0F0F_0F0F;
      for (int i = 0; i < 256; i++) begin
        seed = xs(seed);
        send_word({8'(i), (i == 127) ? 24'h0 : seed[23:0]});
      end
      drain();
    end
    tag = "R9 R10 global only";
    set_cfg(3'b100, 2'b11, 1'b0, 32'h0, 1'b0, 1'b1, 8'd77);
    rand_run(50, 32'hABCD_0005);
    drain();

    // R7: table write meets a read of the same entry
    ready_mode = 1'b0;
    tag = "R7 collision";
    set_cfg(3'b101, 2'b11, 1'b0, 32'h0, 1'b1, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_addr = 1'b0; reg_wr_data = 32'h0000_005A;
    @(negedge clk); reg_wr_en = 1'b0;
    exp_q.push_back(ref_px(32'h0000_005A, 0));
    @(negedge clk); in_valid = 1'b1; in_word = 32'h0000_005A; #1;
    check("R7 in_ready", {31'h0, in_ready}, 32'h1);
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    reg_wr_en = 1'b1; reg_wr_addr = 1'b1; reg_wr_data = 32'h8011_2233;
    @(posedge clk);
    @(negedge clk); reg_wr_en = 1'b0;
    pal_m[8'h5A] = 32'h8011_2233;
    drain();
    tag = "R6 R7 after write";
    send_word(32'h0000_005A);
    drain();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule